// File: doc/BRIEF.md
# Recursive Sine Oscillator

This block produces a sampled sinusoid without a lookup table. A second-order feedback recursion runs on the last two output samples, with a one-sample impulse as its input: y[n] = 2·C·y[n-1] − y[n-2] + S·x[n-1]. C and S are the cosine and sine of the normalised angular frequency, supplied by the user as signed Q1.15 values. After a start strobe, the impulse x is 1.0 for the first sample and 0 from then on. The output is then sin(n·w0) in Q1.15 for n = 0, 1, 2, … Each accepted sample costs two multiplies and three additions. The state is the two previous outputs, the delayed impulse and a pending-impulse flag.

A sample-enable tick asks for the next sample. Samples leave through a one-entry valid/ready output register. A sample waits in that register until the consumer takes it. A tick that arrives while the register holds an untaken sample is dropped, and the recursion does not advance, so no sample is ever lost or skipped. The start strobe and the tick are plain control inputs and have no handshake. The coefficient inputs are read on every accepted tick.

Top module: `recursive_sine_osc`

## Requirements
- R1: After reset, out_valid is 0. Ticks that arrive before the first start strobe produce no sample.
- R2: A start strobe clears out_valid on the next edge. It sets y[n-1], y[n-2] and x[n-1] to zero and makes the next sample's impulse 1.0. A tick in the same cycle as start is ignored.
- R3: A tick is accepted when the block has been started, start is low, and either out_valid is 0 or out_ready is 1. An accepted tick makes out_valid 1 after the same edge, with the new sample on out_data. When out_ready is 1 and no tick is accepted, out_valid drops after the edge.
- R4: The first sample after start is 0. The second sample equals sin_coef.
- R5: Each sample is the Q2.30 sum 2·C·y[n-1] − y[n-2]·2^15 + S·x[n-1]·2^15, with x[n-1] equal to 1 only for the sample directly after the first. It is rounded by adding 2^14 and shifting right arithmetically by 15 bits.
- R6: A rounded result above 32767 is output as 32767, and one below −32768 as −32768. The saturated value is also the value fed back into the recursion.
- R7: While out_valid is 1 and out_ready is 0, out_data and out_valid hold. A tick in that state is dropped and does not advance the recursion.
- R8: A start strobe while the block is running restarts the sequence. The samples that follow are exactly those of a fresh start.
- R9: A change of cos_coef or sin_coef takes effect from the next accepted tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cos_coef | input | 16 | cos(w0), signed Q1.15 |
| sin_coef | input | 16 | sin(w0), signed Q1.15 |
| start | input | 1 | One-cycle strobe: clear state and arm the impulse |
| sample_tick | input | 1 | Request for the next sample |
| out_valid | output | 1 | out_data holds a sample not yet taken |
| out_ready | input | 1 | Consumer takes the sample in this cycle |
| out_data | output | 16 | Output sample, signed Q1.15 |

## Verification
Every stored value feeds straight back into the next sample. A wrong y[n-1], y[n-2] or impulse register therefore appears on out_data at the next accepted tick, and the error compounds from there. This is why the bench compares out_valid and out_data against an independent model on every clock. A wrong impulse timing shows in the first two samples after start. A wrong stall rule shows as a data change, or as a skipped sample, at the first tick during back-pressure. The saturation and restart cases are driven on purpose, because a free-running sine alone would never reach them.

// File: rtl/osc_pkg.sv
package osc_pkg;
  localparam int unsigned SAMPLE_W = 16;
  localparam int unsigned GUARD_W  = 3;
endpackage

// File: rtl/osc_mac.sv
module osc_mac #(
  parameter int unsigned DW    = 16,
  parameter int unsigned ACC_W = 2 * DW + 3
) (
  input  logic signed [DW-1:0]    cos_c,
  input  logic signed [DW-1:0]    sin_c,
  input  logic signed [DW-1:0]    y_d1,
  input  logic signed [DW-1:0]    y_d2,
  input  logic signed [DW:0]      imp_d1,
  output logic signed [ACC_W-1:0] acc
);
  localparam int unsigned FRAC = DW - 1;

  logic signed [ACC_W-1:0] fb_prod;
  logic signed [ACC_W-1:0] imp_prod;
  logic signed [ACC_W-1:0] old_term;

  always_comb begin
    fb_prod  = ACC_W'(cos_c) * ACC_W'(y_d1);
    imp_prod = ACC_W'(sin_c) * ACC_W'(imp_d1);
    old_term = ACC_W'(y_d2) <<< FRAC;
    acc      = (fb_prod <<< 1) - old_term + imp_prod;
  end
endmodule

// File: rtl/osc_round_sat.sv
module osc_round_sat #(
  parameter int unsigned DW    = 16,
  parameter int unsigned ACC_W = 2 * DW + 3
) (
  input  logic signed [ACC_W-1:0] acc,
  output logic signed [DW-1:0]    y
);
  localparam int unsigned FRAC = DW - 1;
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (FRAC - 1);
  localparam logic signed [ACC_W-1:0] HI   = ACC_W'((longint'(1) <<< (DW - 1)) - 1);
  localparam logic signed [ACC_W-1:0] LO   = -HI - ACC_W'(1);

  logic signed [ACC_W-1:0] biased;
  logic signed [ACC_W-1:0] rnd;

  always_comb begin
    biased = acc + HALF;
    rnd    = biased >>> FRAC;
    if (rnd > HI)      y = HI[DW-1:0];
    else if (rnd < LO) y = LO[DW-1:0];
    else               y = rnd[DW-1:0];
  end
endmodule

// File: rtl/osc_state.sv
module osc_state #(
  parameter int unsigned DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 adv,
  input  logic signed [DW-1:0] y_new,
  output logic signed [DW-1:0] y_d1,
  output logic signed [DW-1:0] y_d2,
  output logic signed [DW:0]   imp_d1
);
  localparam int unsigned FRAC = DW - 1;
  localparam logic signed [DW:0] UNIT = (DW + 1)'(1) <<< FRAC;

  logic imp_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_d1    <= '0;
      y_d2    <= '0;
      imp_d1  <= '0;
      imp_now <= 1'b0;
    end else if (clr) begin
      y_d1    <= '0;
      y_d2    <= '0;
      imp_d1  <= '0;
      imp_now <= 1'b1;
    end else if (adv) begin
      y_d2    <= y_d1;
      y_d1    <= y_new;
      imp_d1  <= imp_now ? UNIT : '0;
      imp_now <= 1'b0;
    end
  end
endmodule

// File: rtl/recursive_sine_osc.sv
module recursive_sine_osc #(
  parameter int unsigned DW = osc_pkg::SAMPLE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] cos_coef,
  input  logic [DW-1:0] sin_coef,
  input  logic          start,
  input  logic          sample_tick,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  localparam int unsigned ACC_W = 2 * DW + osc_pkg::GUARD_W;

  logic                    running;
  logic                    accept;
  logic signed [DW-1:0]    y_d1;
  logic signed [DW-1:0]    y_d2;
  logic signed [DW:0]      imp_d1;
  logic signed [ACC_W-1:0] acc;
  logic signed [DW-1:0]    y_new;

  assign accept = running && sample_tick && !start && (!out_valid || out_ready);

  osc_state #(.DW(DW)) u_state (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (start),
    .adv    (accept),
    .y_new  (y_new),
    .y_d1   (y_d1),
    .y_d2   (y_d2),
    .imp_d1 (imp_d1)
  );

  osc_mac #(.DW(DW), .ACC_W(ACC_W)) u_mac (
    .cos_c  ($signed(cos_coef)),
    .sin_c  ($signed(sin_coef)),
    .y_d1   (y_d1),
    .y_d2   (y_d2),
    .imp_d1 (imp_d1),
    .acc    (acc)
  );

  osc_round_sat #(.DW(DW), .ACC_W(ACC_W)) u_sat (
    .acc (acc),
    .y   (y_new)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running   <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (start) begin
      running   <= 1'b1;
      out_valid <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= y_new;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/osc_chk.sv
module osc_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          sample_tick,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data
);
  logic first_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 first_pend <= 1'b0;
    else if (start)             first_pend <= 1'b1;
    else if (out_valid)         first_pend <= 1'b0;
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !start) |=> (out_valid && $stable(out_data)));

  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !out_valid);

  // R3
  valid_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(sample_tick));

  // R4
  first_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (first_pend && out_valid) |-> (out_data == '0));
endmodule

bind recursive_sine_osc osc_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .sample_tick (sample_tick),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data)
);

// File: tb/recursive_sine_osc_bench.sv
module recursive_sine_osc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cos_coef = '0;
  logic [15:0] sin_coef = '0;
  logic        start = 1'b0;
  logic        sample_tick = 1'b0;
  logic        out_ready = 1'b0;
  logic        out_valid;
  logic [15:0] out_data;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit checking = 1'b0;
  bit saw_hi = 1'b0;
  bit saw_lo = 1'b0;
  string phase = "R1";

  // reference model state
  bit m_run = 0, m_imp = 0, m_v = 0;
  int m_y1 = 0, m_y2 = 0, m_x1 = 0, m_d = 0;

  always #4 clk = ~clk;

  recursive_sine_osc u_recursive_sine_osc (
    .clk(clk), .rst_n(rst_n), .cos_coef(cos_coef), .sin_coef(sin_coef),
    .start(start), .sample_tick(sample_tick), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  function automatic int next_sample(int c, int s, int a1, int a2, int xx);
    longint acc;
    longint r;
    acc = 2 * longint'(c) * a1 - longint'(a2) * 32768 + longint'(s) * xx;
    r = (acc + 16384) >>> 15;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_imp = 0; m_v = 0; m_y1 = 0; m_y2 = 0; m_x1 = 0; m_d = 0;
    end else if (start) begin
      m_run = 1; m_imp = 1; m_v = 0; m_y1 = 0; m_y2 = 0; m_x1 = 0;
    end else if (m_run && sample_tick && (!m_v || out_ready)) begin
      m_d = next_sample($signed(cos_coef), $signed(sin_coef), m_y1, m_y2, m_x1);
      m_v = 1;
      m_y2 = m_y1;
      m_y1 = m_d;
      m_x1 = m_imp ? 32768 : 0;
      m_imp = 0;
    end else if (out_ready) begin
      m_v = 0;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      check(out_valid == m_v, {phase, " valid"}, out_valid, m_v);
      if (m_v) begin
        check($signed(out_data) == m_d, {phase, " data"}, $signed(out_data), m_d);
        if ($signed(out_data) == 32767) saw_hi = 1;
        if ($signed(out_data) == -32768) saw_lo = 1;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic drive(int n, bit tk, bit rdy);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sample_tick = tk;
      out_ready = rdy;
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1; sample_tick = 0;
    @(negedge clk); start = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state and ticks before start
    check(out_valid == 0, "R1 reset valid", out_valid, 0);
    checking = 1;
    drive(5, 1, 1);
    check(out_valid == 0, "R1 tick before start", out_valid, 0);

    // R4: first two samples, cos(2pi/16), sin(2pi/16)
    phase = "R4";
    cos_coef = 16'sd30274; sin_coef = 16'sd12540;
    pulse_start();
    drive(1, 1, 0);
    drive(1, 0, 0);
    check(out_valid && out_data == 16'd0, "R4 first sample", $signed(out_data), 0);
    drive(1, 1, 1);
    drive(1, 0, 0);
    check($signed(out_data) == 12540, "R4 second sample", $signed(out_data), 12540);

    // R5 / R3: free run with steady ready
    phase = "R5";
    drive(40, 1, 1);
    phase = "R3";
    drive(4, 0, 1);
    check(out_valid == 0, "R3 valid drops", out_valid, 0);
    drive(10, 1, 0);

    // R7: back-pressure with ticks present
    phase = "R7";
    drive(6, 1, 0);
    drive(3, 0, 1);
    for (int i = 0; i < 60; i++) drive(1, (i % 3) != 0, (i % 4) < 2);

    // R2: start together with a tick, and restart mid-run (R8)
    phase = "R2";
    @(negedge clk); start = 1; sample_tick = 1; out_ready = 1;
    @(negedge clk); start = 0; sample_tick = 0;
    check(out_valid == 0, "R2 start clears", out_valid, 0);
    phase = "R8";
    drive(1, 1, 1);
    drive(1, 0, 1);
    check($signed(out_data) == 0, "R8 restart first", $signed(out_data), 0);
    drive(20, 1, 1);

    // R9: coefficient change mid-run
    phase = "R9";
    @(negedge clk); cos_coef = 16'sd23170; sin_coef = 16'sd23170;
    drive(20, 1, 1);

    // R6: positive and negative saturation
    phase = "R6";
    cos_coef = 16'sd32767; sin_coef = 16'sd32767;
    pulse_start();
    drive(8, 1, 1);
    check(saw_hi, "R6 positive clamp", saw_hi, 1);
    cos_coef = 16'h8000; sin_coef = 16'sd32767;
    pulse_start();
    drive(8, 1, 1);
    check(saw_lo, "R6 negative clamp", saw_lo, 1);

    drive(2, 0, 1);
    checking = 0;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule